// File: doc/BRIEF.md
# Halt Mode Power Sequencer

This block sequences the clocks of a small microcontroller into and out of its deepest low-power state. When the core issues a halt strobe, the block first decides whether the request is honoured. It may stop the part, turn the request into a watchdog reset, or pass it on as a request for a lighter low-power mode. Once halted, the oscillator and every internally clocked domain are gated off. The interrupt-mask bits are held at a forced value so that interrupts are enabled.

Only a reset request or a wake-capable interrupt ends the halt. The oscillator is enabled at once. The CPU and peripheral clocks stay gated until a stabilization count has run on the free-running oscillator-domain clock. The count is either a short or a long one, chosen by a select input that is sampled when the wake event is accepted. The block then returns to normal running and gives a one-cycle resume pulse. With that pulse comes a flag telling the core to fetch the reset vector or to service the interrupt.

The controller has three states. RUN has all clocks on. HALTED has all clocks off. STABILIZING has the oscillator on and the CPU and peripheral clocks off. It has four transitions:
- RUN to HALTED on a qualified halt strobe.
- HALTED to STABILIZING on a reset request or a wake interrupt.
- STABILIZING to STABILIZING on a reset request, which restarts the count.
- STABILIZING to RUN when the count completes.

Top module: `halt_seq`

## Requirements
- R1: A halt strobe in RUN while `osc_irq_en` is 1 keeps all three clock enables at 1. It raises `alt_lowpower_req` for exactly the one cycle after the strobe.
- R2: A halt strobe in RUN with `osc_irq_en`=0, `wdog_on`=1 and `wdog_halt_opt`=0 keeps all clocks on. It raises `wdog_rst_req` for exactly the one cycle after the strobe.
- R3: A halt strobe in RUN with `osc_irq_en`=0, and either `wdog_on`=0 or `wdog_halt_opt`=1, enters HALTED on the next cycle. In HALTED, `osc_en`, `cpu_clk_en` and `periph_clk_en` are all 0, `mask_force_en` is 1 and `mask_force_val` is 2'b10. The mask force stays in effect until the resume cycle.
- R4: If `wake_irq` is already high when halt is entered, the block stays in HALTED for exactly one cycle and then starts stabilizing.
- R5: In HALTED, only `reset_req` or `wake_irq` ends the halt. `other_irq` has no effect, and `osc_en` stays 0.
- R6: When a wake event is accepted, `osc_en` is 1 from the next cycle on. `cpu_clk_en` and `periph_clk_en` stay 0 for exactly N cycles. N is `SHORT_CYCLES` (default 256) if `long_delay` was 0 at acceptance, and `LONG_CYCLES` (default 4096) if it was 1. Later changes of `long_delay` have no effect.
- R7: In the first cycle back in RUN, `resume_pulse` is 1 for exactly one cycle. In that cycle `resume_is_reset` is 1 if reset caused the wake and 0 if an interrupt caused it.
- R8: A `reset_req` during STABILIZING restarts the count from zero with the delay length already latched. It also sets the wake cause to reset.
- R9: If `reset_req` and `wake_irq` arrive in the same HALTED cycle, the wake cause is reset.
- R10: After `rst_n` is released, the block is in RUN. All clock enables are 1, and `wdog_rst_req`, `alt_lowpower_req`, `resume_pulse` and `mask_force_en` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running oscillator-domain clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| halt_strobe | input | 1 | Halt instruction executed (one-cycle strobe) |
| osc_irq_en | input | 1 | Oscillator interrupt enable bit; 1 blocks deep halt |
| wdog_on | input | 1 | Watchdog is running |
| wdog_halt_opt | input | 1 | Option bit: 1 lets halt coexist with the watchdog |
| wake_irq | input | 1 | Interrupt from the wake-capable set |
| other_irq | input | 1 | Interrupt that cannot wake the part |
| reset_req | input | 1 | Reset request (wake source, highest priority) |
| long_delay | input | 1 | Stabilization length select: 0 short, 1 long |
| osc_en | output | 1 | Oscillator enable |
| cpu_clk_en | output | 1 | CPU clock enable |
| periph_clk_en | output | 1 | Internally clocked peripheral clock enable |
| mask_force_en | output | 1 | Interrupt-mask override active |
| mask_force_val | output | 2 | Forced interrupt-mask value |
| wdog_rst_req | output | 1 | Watchdog reset request pulse |
| alt_lowpower_req | output | 1 | Request for the lighter low-power mode |
| resume_pulse | output | 1 | One-cycle pulse on return to RUN |
| resume_is_reset | output | 1 | With the resume pulse: 1 fetch reset vector, 0 service interrupt |

## Verification
The bench sweeps every combination of the four qualification inputs, both delay lengths and both wake causes, and measures the exact gated window. An off-by-one counter, or one that reads the delay select live rather than latching it, shows up as a wrong cycle count. A wake interrupt that is already pending at entry must give exactly one halted cycle; a design that skips HALTED, or that waits for a new edge, breaks that. A reset during stabilization must lengthen the window by precisely the cycles already spent and flip the cause to reset. A design that ignores it, or that resamples the select, resumes early or reports the interrupt path. Non-wake interrupts are held high while halted, which exposes any design that lets them restart the oscillator.

// File: rtl/halt_seq_pkg.sv
package halt_seq_pkg;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_HALTED = 2'd1,
        ST_STAB   = 2'd2
    } hs_state_e;

    localparam logic [1:0] MASK_OPEN = 2'b10;

endpackage

// File: rtl/halt_entry_qual.sv
module halt_entry_qual (
    input  logic in_run,
    input  logic halt_strobe,
    input  logic osc_irq_en,
    input  logic wdog_on,
    input  logic wdog_halt_opt,
    output logic go_halt,
    output logic go_wdog,
    output logic go_alt
);
    logic req;

    always_comb begin
        req     = in_run && halt_strobe;
        go_alt  = req && osc_irq_en;
        go_wdog = req && !osc_irq_en && wdog_on && !wdog_halt_opt;
        go_halt = req && !osc_irq_en && !(wdog_on && !wdog_halt_opt);
    end
endmodule

// File: rtl/halt_stab_counter.sv
module halt_stab_counter #(
    parameter int SHORT_CYCLES = 256,
    parameter int LONG_CYCLES  = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic restart,
    input  logic run,
    input  logic long_sel,
    output logic done
);
    localparam int CW = (LONG_CYCLES > 1) ? $clog2(LONG_CYCLES) : 1;
    localparam logic [CW-1:0] SHORT_LAST = CW'(SHORT_CYCLES - 1);
    localparam logic [CW-1:0] LONG_LAST  = CW'(LONG_CYCLES - 1);

    logic [CW-1:0] cnt_q;
    logic          long_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            long_q <= 1'b0;
        end else if (load) begin
            cnt_q  <= '0;
            long_q <= long_sel;
        end else if (restart) begin
            cnt_q  <= '0;
        end else if (run) begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        done = (cnt_q == (long_q ? LONG_LAST : SHORT_LAST));
    end
endmodule

// File: rtl/halt_seq.sv
module halt_seq
    import halt_seq_pkg::*;
#(
    parameter int SHORT_CYCLES = 256,
    parameter int LONG_CYCLES  = 4096
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       halt_strobe,
    input  logic       osc_irq_en,
    input  logic       wdog_on,
    input  logic       wdog_halt_opt,
    input  logic       wake_irq,
    input  logic       other_irq,
    input  logic       reset_req,
    input  logic       long_delay,
    output logic       osc_en,
    output logic       cpu_clk_en,
    output logic       periph_clk_en,
    output logic       mask_force_en,
    output logic [1:0] mask_force_val,
    output logic       wdog_rst_req,
    output logic       alt_lowpower_req,
    output logic       resume_pulse,
    output logic       resume_is_reset
);
    hs_state_e state_q, state_d;
    logic      go_halt, go_wdog, go_alt;
    logic      cnt_load, cnt_restart, cnt_done;
    logic      cause_rst_q, cause_rst_d;
    logic      resume_d;
    logic      unused_irq;

    assign unused_irq = other_irq;

    halt_entry_qual qual_i (
        .in_run        (state_q == ST_RUN),
        .halt_strobe   (halt_strobe),
        .osc_irq_en    (osc_irq_en),
        .wdog_on       (wdog_on),
        .wdog_halt_opt (wdog_halt_opt),
        .go_halt       (go_halt),
        .go_wdog       (go_wdog),
        .go_alt        (go_alt)
    );

    halt_stab_counter #(
        .SHORT_CYCLES (SHORT_CYCLES),
        .LONG_CYCLES  (LONG_CYCLES)
    ) cnt_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .restart  (cnt_restart),
        .run      (state_q == ST_STAB),
        .long_sel (long_delay),
        .done     (cnt_done)
    );

    // next state and wake bookkeeping
    always_comb begin
        state_d     = state_q;
        cause_rst_d = cause_rst_q;
        cnt_load    = 1'b0;
        cnt_restart = 1'b0;
        resume_d    = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                if (go_halt) state_d = ST_HALTED;
            end
            ST_HALTED: begin
                if (reset_req || wake_irq) begin
                    state_d     = ST_STAB;
                    cause_rst_d = reset_req;
                    cnt_load    = 1'b1;
                end
            end
            ST_STAB: begin
                if (reset_req) begin
                    cause_rst_d = 1'b1;
                    cnt_restart = 1'b1;
                end else if (cnt_done) begin
                    state_d  = ST_RUN;
                    resume_d = 1'b1;
                end
            end
            default: state_d = ST_RUN;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q          <= ST_RUN;
            cause_rst_q      <= 1'b0;
            resume_pulse     <= 1'b0;
            wdog_rst_req     <= 1'b0;
            alt_lowpower_req <= 1'b0;
        end else begin
            state_q          <= state_d;
            cause_rst_q      <= cause_rst_d;
            resume_pulse     <= resume_d;
            wdog_rst_req     <= go_wdog;
            alt_lowpower_req <= go_alt;
        end
    end

    // state-decoded outputs
    always_comb begin
        osc_en         = 1'b1;
        cpu_clk_en     = 1'b1;
        periph_clk_en  = 1'b1;
        mask_force_en  = 1'b0;
        mask_force_val = MASK_OPEN;
        unique case (state_q)
            ST_RUN: ;
            ST_HALTED: begin
                osc_en        = 1'b0;
                cpu_clk_en    = 1'b0;
                periph_clk_en = 1'b0;
                mask_force_en = 1'b1;
            end
            ST_STAB: begin
                cpu_clk_en    = 1'b0;
                periph_clk_en = 1'b0;
                mask_force_en = 1'b1;
            end
            default: ;
        endcase
        resume_is_reset = cause_rst_q;
    end
endmodule

// File: rtl/halt_seq_chk.sv
module halt_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       halt_strobe,
    input logic       osc_irq_en,
    input logic       wdog_on,
    input logic       wdog_halt_opt,
    input logic       wake_irq,
    input logic       reset_req,
    input logic       osc_en,
    input logic       cpu_clk_en,
    input logic       periph_clk_en,
    input logic       mask_force_en,
    input logic [1:0] mask_force_val,
    input logic       wdog_rst_req,
    input logic       alt_lowpower_req,
    input logic       resume_pulse
);
    a_r1_alt_keeps_clocks: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_clk_en && halt_strobe && osc_irq_en) |=> (cpu_clk_en && osc_en && alt_lowpower_req));

    a_r2_wdog_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_clk_en && halt_strobe && !osc_irq_en && wdog_on && !wdog_halt_opt)
        |=> (wdog_rst_req && cpu_clk_en));

    a_r3_mask_forced: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en |-> (mask_force_en && mask_force_val == 2'b10 && !cpu_clk_en && !periph_clk_en));

    a_r5_stays_halted: assert property (@(posedge clk) disable iff (!rst_n)
        (!osc_en && !reset_req && !wake_irq) |=> !osc_en);

    a_r6_gated_until_resume: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_clk_en) |-> (resume_pulse && osc_en && periph_clk_en));

    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        resume_pulse |=> !resume_pulse);
endmodule

bind halt_seq halt_seq_chk chk_i (
    .clk              (clk),
    .rst_n            (rst_n),
    .halt_strobe      (halt_strobe),
    .osc_irq_en       (osc_irq_en),
    .wdog_on          (wdog_on),
    .wdog_halt_opt    (wdog_halt_opt),
    .wake_irq         (wake_irq),
    .reset_req        (reset_req),
    .osc_en           (osc_en),
    .cpu_clk_en       (cpu_clk_en),
    .periph_clk_en    (periph_clk_en),
    .mask_force_en    (mask_force_en),
    .mask_force_val   (mask_force_val),
    .wdog_rst_req     (wdog_rst_req),
    .alt_lowpower_req (alt_lowpower_req),
    .resume_pulse     (resume_pulse)
);

// File: tb/halt_seq_tb_top.sv
`timescale 1ns/1ps
module halt_seq_tb_top;
    localparam int SHORT_N = 6;
    localparam int LONG_N  = 13;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic halt_strobe = 0, osc_irq_en = 0, wdog_on = 0, wdog_halt_opt = 0;
    logic wake_irq = 0, other_irq = 0, reset_req = 0, long_delay = 0;
    logic osc_en, cpu_clk_en, periph_clk_en, mask_force_en;
    logic [1:0] mask_force_val;
    logic wdog_rst_req, alt_lowpower_req, resume_pulse, resume_is_reset;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    halt_seq #(.SHORT_CYCLES(SHORT_N), .LONG_CYCLES(LONG_N)) dut_i (
        .clk(clk), .rst_n(rst_n), .halt_strobe(halt_strobe), .osc_irq_en(osc_irq_en),
        .wdog_on(wdog_on), .wdog_halt_opt(wdog_halt_opt), .wake_irq(wake_irq),
        .other_irq(other_irq), .reset_req(reset_req), .long_delay(long_delay),
        .osc_en(osc_en), .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en),
        .mask_force_en(mask_force_en), .mask_force_val(mask_force_val),
        .wdog_rst_req(wdog_rst_req), .alt_lowpower_req(alt_lowpower_req),
        .resume_pulse(resume_pulse), .resume_is_reset(resume_is_reset)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // count gated cycles (observed at negedges) until the CPU clock returns
    task automatic count_gated(output int n);
        n = 0;
        while (!cpu_clk_en && n < 10000) begin
            n++;
            @(negedge clk);
        end
    endtask

    // one halt attempt with a given configuration and wake cause
    task automatic halt_case(input bit oie, input bit wd, input bit opt,
                             input bit lng, input bit by_reset);
        int n;
        bit enter;
        enter = !oie && !(wd && !opt);
        @(negedge clk);
        osc_irq_en = oie; wdog_on = wd; wdog_halt_opt = opt;
        halt_strobe = 1'b1;
        @(negedge clk);
        halt_strobe = 1'b0;
        if (oie) begin
            chk("R1 clocks", {osc_en, cpu_clk_en, periph_clk_en}, 7);
            chk("R1 alt pulse", alt_lowpower_req, 1);
            @(negedge clk);
            chk("R1 alt one cycle", alt_lowpower_req, 0);
        end else if (!enter) begin
            chk("R2 clocks", {osc_en, cpu_clk_en, periph_clk_en}, 7);
            chk("R2 wdog pulse", wdog_rst_req, 1);
            @(negedge clk);
            chk("R2 wdog one cycle", wdog_rst_req, 0);
        end else begin
            chk("R3 halted clocks", {osc_en, cpu_clk_en, periph_clk_en}, 0);
            chk("R3 mask force", {mask_force_en, mask_force_val}, 3'b110);
            other_irq = 1'b1;
            repeat (3) @(negedge clk);
            chk("R5 other irq ignored", osc_en, 0);
            other_irq = 1'b0;
            long_delay = lng;
            if (by_reset) reset_req = 1'b1; else wake_irq = 1'b1;
            @(negedge clk);
            reset_req = 1'b0; wake_irq = 1'b0;
            long_delay = !lng;
            chk("R6 osc on", osc_en, 1);
            chk("R3 mask held in stab", mask_force_en, 1);
            count_gated(n);
            chk("R6 gated length", n, lng ? LONG_N : SHORT_N);
            chk("R7 resume pulse", resume_pulse, 1);
            chk("R7 cause", resume_is_reset, by_reset);
            @(negedge clk);
            chk("R7 pulse one cycle", resume_pulse, 0);
        end
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 reset state", {osc_en, cpu_clk_en, periph_clk_en, mask_force_en,
                                wdog_rst_req, alt_lowpower_req, resume_pulse}, 7'b1110000);

        for (int c = 0; c < 32; c++)
            halt_case(c[4], c[3], c[2], c[1], c[0]);

        // R4: wake interrupt pending at entry
        @(negedge clk);
        osc_irq_en = 0; wdog_on = 0; long_delay = 0;
        halt_strobe = 1'b1; wake_irq = 1'b1;
        @(negedge clk);
        halt_strobe = 1'b0;
        chk("R4 one halted cycle", osc_en, 0);
        @(negedge clk);
        wake_irq = 1'b0;
        chk("R4 immediate wake", {osc_en, cpu_clk_en}, 2'b10);
        count_gated(n);
        chk("R4 gated length", n, SHORT_N);
        chk("R4 cause irq", {resume_pulse, resume_is_reset}, 2'b10);

        // R9: reset and interrupt together
        for (int lng = 0; lng < 2; lng++) begin
            @(negedge clk);
            halt_strobe = 1'b1; long_delay = lng[0];
            @(negedge clk);
            halt_strobe = 1'b0;
            reset_req = 1'b1; wake_irq = 1'b1;
            @(negedge clk);
            reset_req = 1'b0; wake_irq = 1'b0;
            count_gated(n);
            chk("R9 gated length", n, lng ? LONG_N : SHORT_N);
            chk("R9 reset wins", {resume_pulse, resume_is_reset}, 2'b11);
        end

        // R8: reset during stabilization, at several offsets
        for (int k = 1; k < SHORT_N; k++) begin
            int tot;
            @(negedge clk);
            halt_strobe = 1'b1; long_delay = 1'b0;
            @(negedge clk);
            halt_strobe = 1'b0; wake_irq = 1'b1;
            @(negedge clk);
            wake_irq = 1'b0;
            long_delay = 1'b1;
            tot = 0;
            repeat (k - 1) begin tot++; @(negedge clk); end
            tot++;
            reset_req = 1'b1;
            @(negedge clk);
            reset_req = 1'b0;
            count_gated(n);
            chk("R8 restarted length", tot + n, k + SHORT_N);
            chk("R8 cause reset", {resume_pulse, resume_is_reset}, 2'b11);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule